// File: doc/BRIEF.md
# Three-Bus Register Datapath with Fetch/Execute Sequencer

This block is a 32-bit processor datapath built around three internal buses. Two read ports of a general register file drive bus A and bus B. The ALU combines its two inputs and drives bus C, which feeds the register file write port, the memory address register and the instruction register. A dedicated incrementer advances the program counter, so the ALU is never needed for that. A small sequencer fetches one instruction word over a request/acknowledge memory port and then executes a three-operand register ALU instruction in a single step.

Every instruction takes four phases:
- Address: the PC goes onto bus B, and the ALU passes B to bus C, which loads the address register. The PC is incremented and a read is requested.
- Wait: the sequencer waits for the memory-complete strobe.
- Load: the captured data word goes onto bus B and through the ALU into the instruction register.
- Execute: the two source registers are read, and the result is written to the destination register in the same cycle.

Memory port rules:
- The read request (`mem_rd`) rises the cycle after the address phase and stays high until the memory answers. It is a level.
- The memory answers by asserting `mem_mfc` for one cycle with `mem_rdata` valid. The data word is taken in that cycle, and the request drops at the following clock edge.
- The memory may hold off its answer for any number of cycles. The sequencer stays in its wait phase for as long as that takes, so this is the only back-pressure path.
- A strobe that arrives while no read is pending has no effect.

Top module: `tbus_datapath`

## Requirements
- R1: While `rst_n` is low and right after it: `pc` is 0, `mem_rd` is 0, `instr_done` is 0 and `rf_we` is 0. Each general register k resets to the value k.
- R2: In the address phase of each instruction, the address register loads the current PC through bus B and bus C, and the PC advances by 4. When that instruction completes, `mem_addr` is 4·k and `pc` is 4·(k+1) for the k-th instruction (counting from 0).
- R3: `mem_rd` stays high until `mem_mfc` is seen, and the data word is captured in that cycle. An instruction answered after L extra wait cycles completes exactly L+4 cycles after the previous one.
- R4: The instruction word fields are fixed as follows:
  - opcode: bits [31:28]
  - destination: bits [23:16]
  - source A: bits [15:8]
  - source B: bits [7:0]

  Only the low log2(NREG) bits of each register field are used. Bits [27:24] and the upper field bits are ignored.
- R5: Opcode 0 writes A+B and opcode 1 writes A−B, both modulo 2^32.
- R6: Opcode 2 writes A AND B, opcode 3 writes A OR B, and opcode 4 writes A XOR B.
- R7: Opcode 5 writes 1 if A is less than B as signed two's-complement values, and 0 otherwise.
- R8: Opcode 6 copies A unchanged to bus C, and opcode 7 copies B unchanged.
- R9: Reads in the execute step see the register values from before that step's write. A write becomes visible to the next instruction, including when a register is both source and destination.
- R10: Opcodes 8 to 15 write no register, but the instruction still completes. Registers named in such a word keep their values.
- R11: `instr_done` is high for exactly one cycle per instruction. `rf_we` is high only in that cycle, and `bus_c` then carries the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | XLEN | Memory address register contents |
| mem_rd | output | 1 | Read request, held until the memory answers |
| mem_rdata | input | XLEN | Read data, valid while `mem_mfc` is high |
| mem_mfc | input | 1 | Memory-complete strobe, one cycle |
| pc | output | XLEN | Program counter |
| bus_c | output | XLEN | ALU result bus |
| rf_we | output | 1 | Register file write enable |
| rf_wsel | output | $clog2(NREG) | Register file write index |
| instr_done | output | 1 | End-of-instruction pulse |

## Verification
The bench builds the block with its defaults: XLEN of 32 and eight registers, so each register field uses three bits. Eight registers let a short program chain every opcode through results written by earlier instructions. The program also reaches the following cases:
- a register read and written in the same step;
- both read ports on the same register;
- upper field bits set in an instruction word;
- a no-write opcode.

The memory model varies its answer delay from zero to six cycles. This makes the wait phase and the per-instruction period observable. A second reset in mid-program confirms that the register seeds return.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_SUB   = 4'd1;
  localparam logic [3:0] OP_AND   = 4'd2;
  localparam logic [3:0] OP_OR    = 4'd3;
  localparam logic [3:0] OP_XOR   = 4'd4;
  localparam logic [3:0] OP_SLT   = 4'd5;
  localparam logic [3:0] OP_PASSA = 4'd6;
  localparam logic [3:0] OP_PASSB = 4'd7;

  localparam int OPC_LSB  = 28;
  localparam int DST_LSB  = 16;
  localparam int SRCA_LSB = 8;
  localparam int SRCB_LSB = 0;

  typedef enum logic [1:0] {BSRC_RF, BSRC_PC, BSRC_MDR} bsrc_e;
  typedef enum logic [1:0] {ST_ADDR, ST_WAIT, ST_LDIR, ST_EXEC} step_e;
endpackage

// File: rtl/tbus_alu.sv
module tbus_alu
  import tbus_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_PASSA: y = a;
      OP_PASSB: y = b;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/tbus_regfile.sv
module tbus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rsel_a,
  input  logic [AW-1:0]   rsel_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  input  logic            we,
  input  logic [AW-1:0]   wsel,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[i] <= XLEN'(i);
      else if (we && wsel == AW'(i))       regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[rsel_a];
  assign rdata_b = regs[rsel_b];
endmodule

// File: rtl/tbus_seq.sv
module tbus_seq
  import tbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_mfc,
  input  logic [3:0] opc,
  output logic       mem_rd,
  output bsrc_e      bsel,
  output logic       a_four,
  output logic [3:0] alu_op,
  output logic       mar_ld,
  output logic       pc_inc,
  output logic       mdr_ld,
  output logic       ir_ld,
  output logic       rf_we,
  output logic       done
);
  step_e state, state_nx;
  logic  rd_q;

  always_comb begin
    case (state)
      ST_ADDR: state_nx = ST_WAIT;
      ST_WAIT: state_nx = mem_mfc ? ST_LDIR : ST_WAIT;
      ST_LDIR: state_nx = ST_EXEC;
      default: state_nx = ST_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ADDR;
      rd_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_ADDR)               rd_q <= 1'b1;
      else if (state == ST_WAIT && mem_mfc) rd_q <= 1'b0;
    end
  end

  always_comb begin
    bsel   = BSRC_RF;
    a_four = 1'b0;
    alu_op = OP_PASSB;
    mar_ld = 1'b0;
    pc_inc = 1'b0;
    mdr_ld = 1'b0;
    ir_ld  = 1'b0;
    rf_we  = 1'b0;
    done   = 1'b0;
    case (state)
      ST_ADDR: begin
        bsel   = BSRC_PC;
        a_four = 1'b1;
        mar_ld = 1'b1;
        pc_inc = 1'b1;
      end
      ST_WAIT: mdr_ld = mem_mfc;
      ST_LDIR: begin
        bsel  = BSRC_MDR;
        ir_ld = 1'b1;
      end
      default: begin
        alu_op = opc;
        rf_we  = ~opc[3];
        done   = 1'b1;
      end
    endcase
  end

  assign mem_rd = rd_q;

  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !mem_mfc) |=> rd_q);
  // R3
  mfc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && mem_mfc) |=> (state == ST_LDIR && !rd_q));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tbus_datapath.sv
module tbus_datapath
  import tbus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [XLEN-1:0]         mem_addr,
  output logic                    mem_rd,
  input  logic [XLEN-1:0]         mem_rdata,
  input  logic                    mem_mfc,
  output logic [XLEN-1:0]         pc,
  output logic [XLEN-1:0]         bus_c,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_wsel,
  output logic                    instr_done
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic [XLEN-1:0] bus_a, bus_b, rf_b, alu_a, alu_y;
  logic [3:0]      opc, alu_op;
  logic [AW-1:0]   dst_i, srca_i, srcb_i;
  bsrc_e           bsel;
  logic            a_four, mar_ld, pc_inc, mdr_ld, ir_ld, we_i, done_i;

  assign opc    = ir_q[OPC_LSB +: 4];
  assign dst_i  = ir_q[DST_LSB +: AW];
  assign srca_i = ir_q[SRCA_LSB +: AW];
  assign srcb_i = ir_q[SRCB_LSB +: AW];

  tbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mem_mfc(mem_mfc), .opc(opc),
    .mem_rd(mem_rd), .bsel(bsel), .a_four(a_four), .alu_op(alu_op),
    .mar_ld(mar_ld), .pc_inc(pc_inc), .mdr_ld(mdr_ld), .ir_ld(ir_ld),
    .rf_we(we_i), .done(done_i)
  );

  tbus_regfile #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .rsel_a(srca_i), .rsel_b(srcb_i),
    .rdata_a(bus_a), .rdata_b(rf_b), .we(we_i), .wsel(dst_i), .wdata(bus_c)
  );

  always_comb begin
    case (bsel)
      BSRC_PC:  bus_b = pc_q;
      BSRC_MDR: bus_b = mdr_q;
      default:  bus_b = rf_b;
    endcase
  end

  assign alu_a = a_four ? XLEN'(4) : bus_a;

  tbus_alu #(.XLEN(XLEN)) u_alu (.op(alu_op), .a(alu_a), .b(bus_b), .y(alu_y));

  assign bus_c = alu_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_inc) pc_q  <= pc_q + XLEN'(4);
      if (mar_ld) mar_q <= bus_c;
      if (mdr_ld) mdr_q <= mem_rdata;
      if (ir_ld)  ir_q  <= bus_c;
    end
  end

  assign mem_addr   = mar_q;
  assign pc         = pc_q;
  assign rf_we      = we_i;
  assign rf_wsel    = dst_i;
  assign instr_done = done_i;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> (pc_q == $past(pc_q) + XLEN'(4)));
  // R2
  mar_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> (mar_q + XLEN'(4) == pc_q));
  // R10
  nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && ir_q[OPC_LSB+3]) |-> !rf_we);
endmodule

// File: tb/tb_tbus_datapath.sv
module tb_tbus_datapath;
  localparam int XLEN = 32;
  localparam int NREG = 8;
  localparam int NV   = 15;

  typedef struct packed {
    logic [31:0] word;
    logic        we;
    logic [2:0]  sel;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0006_0405, 1'b1, 3'd6, 32'h0000_0009, 4'd5},
    '{32'h1001_0207, 1'b1, 3'd1, 32'hFFFF_FFFB, 4'd5},
    '{32'h5003_0102, 1'b1, 3'd3, 32'h0000_0001, 4'd7},
    '{32'h2005_0607, 1'b1, 3'd5, 32'h0000_0001, 4'd6},
    '{32'h3004_0602, 1'b1, 3'd4, 32'h0000_000B, 4'd6},
    '{32'h4007_0106, 1'b1, 3'd7, 32'hFFFF_FFF2, 4'd6},
    '{32'h6002_0400, 1'b1, 3'd2, 32'h0000_000B, 4'd8},
    '{32'h7000_0106, 1'b1, 3'd0, 32'h0000_0009, 4'd8},
    '{32'h5006_0201, 1'b1, 3'd6, 32'h0000_0000, 4'd7},
    '{32'h0003_0303, 1'b1, 3'd3, 32'h0000_0002, 4'd9},
    '{32'h1005_0504, 1'b1, 3'd5, 32'hFFFF_FFF6, 4'd9},
    '{32'h9002_0304, 1'b0, 3'd2, 32'h0000_0000, 4'd10},
    '{32'h6001_0500, 1'b1, 3'd1, 32'hFFFF_FFF6, 4'd9},
    '{32'h0000_0200, 1'b1, 3'd0, 32'h0000_0014, 4'd10},
    '{32'h0AF9_0B16, 1'b1, 3'd1, 32'h0000_0002, 4'd4}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XLEN-1:0] mem_addr, mem_rdata, pc, bus_c;
  logic            mem_rd, mem_mfc, rf_we, instr_done;
  logic [2:0]      rf_wsel;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int cyc    = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tbus_datapath #(.XLEN(XLEN), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .pc(pc), .bus_c(bus_c),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .instr_done(instr_done)
  );

  function automatic logic [31:0] fetch_word(input logic [31:0] a);
    int idx;
    idx = int'(a >> 2);
    if (idx < NV) return VECS[idx].word;
    return 32'hF000_0000;
  endfunction

  function automatic string rtag(input int n);
    case (n)
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    mem_mfc   = 1'b0;
    mem_rdata = '0;
  end

  always @(negedge clk) begin
    mem_mfc <= 1'b0;
    if (!rst_n) wcnt = 0;
    else if (mem_rd && !mem_mfc) begin
      if (wcnt >= lat) begin
        mem_mfc   <= 1'b1;
        mem_rdata <= fetch_word(mem_addr);
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (instr_done) begin
        ok = 1'b1;
        return;
      end
    end
    checks++;
    fails++;
    $display("FAIL watchdog: actual no instr_done expected instr_done within 200 cycles");
  endtask

  initial begin
    bit ok;
    int last_cyc;
    int cur_lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc, 32'd0);
    chk("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
    chk("R1 instr_done", {31'd0, instr_done}, 32'd0);
    chk("R1 rf_we", {31'd0, rf_we}, 32'd0);
    lat = 0;
    cur_lat = 0;
    last_cyc = 0;
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      wait_done(ok);
      if (!ok) break;
      if (VECS[k].we) begin
        chk({rtag(int'(VECS[k].req)), " value"}, bus_c, VECS[k].val);
        chk({rtag(int'(VECS[k].req)), " index"}, {29'd0, rf_wsel}, {29'd0, VECS[k].sel});
      end
      chk({rtag(int'(VECS[k].req)), " write enable"}, {31'd0, rf_we}, {31'd0, VECS[k].we});
      // R2 address and PC after fetch
      chk("R2 mem_addr", mem_addr, 32'(4 * k));
      chk("R2 pc", pc, 32'(4 * (k + 1)));
      // R3 period follows memory latency
      if (k > 0) chk("R3 period", 32'(cyc - last_cyc), 32'(cur_lat + 4));
      last_cyc = cyc;
      cur_lat = (k == 3) ? 6 : ((k + 1) % 3);
      lat = cur_lat;
      @(negedge clk);
      // R11 single-cycle completion
      chk("R11 done pulse", {31'd0, instr_done}, 32'd0);
      chk("R11 write only at done", {31'd0, rf_we}, 32'd0);
    end

    // R1 mid-run reset restores register seeds
    rst_n = 1'b0;
    lat = 0;
    repeat (2) @(negedge clk);
    chk("R1 pc after reset", pc, 32'd0);
    chk("R1 mem_rd after reset", {31'd0, mem_rd}, 32'd0);
    rst_n = 1'b1;
    wait_done(ok);
    if (ok) begin
      chk("R1 seeds r4+r5", bus_c, 32'd9);
      chk("R1 seed index", {29'd0, rf_wsel}, 32'd6);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule